// File: doc/BRIEF.md
# FLL Lock and Loss-of-Lock Detector

This block watches the output of a digitally controlled oscillator inside a frequency-locked loop. It counts oscillator pulses over each comparison cycle. At the end of the cycle it subtracts the programmed multiplier, which gives a signed count error. Two windows act on that error:

- A narrow acquisition window. The error must stay inside it for a programmed number of consecutive cycles before the loop is declared locked.
- A wider hold window. The error must stay inside it for the loop to remain locked.

Leaving the hold window while locked drops the lock and raises a sticky loss-of-lock flag. Only an acknowledge or a reset clears that flag.

The block also feeds the loop filter. While unlocked, every count error goes straight to the filter. While locked, the filter receives one update every four comparison cycles, and its value is the floored mean of those four errors. A divider-select output asks the clock output stage for an extra halving until the first lock after entering the engaged mode. After that first lock it asks for no extra halving, even if lock is later lost. Dropping the mode enable returns all loop state to its starting point. The sticky flag survives this.

Top module: `fll_lock_det`

## Requirements
- R1: On the cycle after `cmp_end` is high, `err_valid` is high for one cycle and `count_err` equals the number of cycles in which `dco_pulse` was high since the previous end strobe, minus the effective multiplier. A pulse on the same cycle as the end strobe belongs to the cycle that is ending.
- R2: A `mult_val` below 4 is used as 4. Any other value is used as given.
- R3: While unlocked, `locked` rises one cycle after the sample that completes `qual_count` consecutive samples with `lock_lo < count_err < lock_hi`. The comparison is signed and strict. A sample outside this window restarts the run. A `qual_count` of 0 behaves as 1.
- R4: While locked, a sample with `unlock_lo < count_err < unlock_hi` keeps the lock. Any other sample clears `locked` and sets `lol_flag` one cycle later.
- R5: `lol_flag` stays set until a cycle in which `lol_ack` is high and no new loss occurs. A new lock does not clear it, and neither does a mode exit.
- R6: Every sample taken while unlocked gives `filt_upd` high one cycle later, with `filt_err` equal to that raw `count_err`. This includes the sample that achieves lock and the sample that loses it.
- R7: While lock holds, `filt_upd` pulses only on every fourth retained sample. Its `filt_err` is the sum of those four errors, arithmetically shifted right by 2.
- R8: `div_half` is 1 (divide by 2R) from reset or mode entry until the first lock. It is 0 (divide by R) after that, including after a loss of lock.
- R9: While `engage` is low, `locked` is 0, `div_half` is 1, and `err_valid` and `filt_upd` are 0. The pulse count, the qualification run and the averaging are all cleared.
- R10: After reset, `count_err`, `err_valid`, `filt_upd`, `filt_err`, `locked` and `lol_flag` are 0 and `div_half` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| engage | input | 1 | Engaged-mode enable |
| dco_pulse | input | 1 | One-cycle strobe per oscillator pulse |
| cmp_end | input | 1 | End of comparison cycle strobe |
| mult_val | input | CNT_W | Programmed multiplier |
| lock_lo | input | CNT_W+1 | Acquisition window lower bound (signed, exclusive) |
| lock_hi | input | CNT_W+1 | Acquisition window upper bound (signed, exclusive) |
| unlock_lo | input | CNT_W+1 | Hold window lower bound (signed, exclusive) |
| unlock_hi | input | CNT_W+1 | Hold window upper bound (signed, exclusive) |
| qual_count | input | QUAL_W | Consecutive in-window samples needed to lock |
| lol_ack | input | 1 | Clears the loss-of-lock flag |
| count_err | output | CNT_W+1 | Signed count error of the last cycle |
| err_valid | output | 1 | `count_err` updated this cycle |
| filt_upd | output | 1 | Loop-filter update strobe |
| filt_err | output | CNT_W+1 | Signed error for the loop filter |
| locked | output | 1 | Lock status |
| lol_flag | output | 1 | Sticky loss-of-lock flag |
| div_half | output | 1 | 1 selects divide by 2R, 0 selects divide by R |

## Verification
The assertions check the following on every cycle:
- A rise of `locked` is always preceded by a sample inside the acquisition window.
- A sample outside the hold window always drops the lock and sets the flag.
- The flag never clears without an acknowledge.
- `div_half` never returns to 1 while engaged.
- A filter strobe always follows a sample.
- A mode exit forces the idle state.

Only the bench's scenarios can show the rest. That covers the exact error arithmetic, the multiplier floor, the length of the qualification run and its restart on an outlier, and the four-sample phase and floored mean. The bench sweeps pulse counts across several multipliers and sample-count settings, and compares each result against an arithmetic model.

// File: rtl/fll_pkg.sv
package fll_pkg;
  // Smallest multiplier the loop may run with.
  localparam int MIN_MULT = 4;

  typedef enum logic {
    ST_ACQ  = 1'b0,
    ST_HOLD = 1'b1
  } lock_st_e;
endpackage

// File: rtl/fll_pulse_cnt.sv
// Counts oscillator pulses over one comparison cycle and forms the signed
// count error against the floored multiplier.
module fll_pulse_cnt #(
  parameter int CNT_W    = 10,
  parameter int MIN_MULT = fll_pkg::MIN_MULT,
  localparam int ERR_W   = CNT_W + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    engage,
  input  logic                    dco_pulse,
  input  logic                    cmp_end,
  input  logic [CNT_W-1:0]        mult_val,
  output logic signed [ERR_W-1:0] err_q,
  output logic                    valid_q
);
  localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_MULT);
  localparam logic [CNT_W-1:0] MAX_V = {CNT_W{1'b1}};

  logic [CNT_W-1:0]        cnt_q;
  logic [CNT_W-1:0]        cnt_n;
  logic [CNT_W-1:0]        eff_mult;
  logic signed [ERR_W-1:0] diff;

  always_comb begin
    // Saturate instead of wrapping on a runaway oscillator.
    if (dco_pulse && (cnt_q != MAX_V)) cnt_n = cnt_q + 1'b1;
    else                               cnt_n = cnt_q;
    eff_mult = (mult_val < MIN_V) ? MIN_V : mult_val;
    diff     = $signed({1'b0, cnt_n}) - $signed({1'b0, eff_mult});
  end

  always_ff @(posedge clk) begin
    if (rst || !engage) begin
      cnt_q   <= '0;
      err_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= cmp_end;
      if (cmp_end) begin
        err_q <= diff;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_n;
      end
    end
  end
endmodule

// File: rtl/fll_lock_track.sv
// Hysteretic lock tracker with consecutive-sample qualification, sticky
// loss-of-lock flag and post-divide selection.
module fll_lock_track #(
  parameter int ERR_W  = 11,
  parameter int QUAL_W = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    engage,
  input  logic signed [ERR_W-1:0] err,
  input  logic                    valid,
  input  logic signed [ERR_W-1:0] lock_lo,
  input  logic signed [ERR_W-1:0] lock_hi,
  input  logic signed [ERR_W-1:0] unlock_lo,
  input  logic signed [ERR_W-1:0] unlock_hi,
  input  logic [QUAL_W-1:0]       qual_count,
  input  logic                    lol_ack,
  output logic                    locked,
  output logic                    lol_flag,
  output logic                    div_half,
  output logic                    keep_lock
);
  import fll_pkg::*;

  lock_st_e          st_q;
  logic [QUAL_W-1:0] run_q;
  logic [QUAL_W-1:0] qual_eff;
  logic              in_acq;
  logic              in_hold;
  logic              lose;
  logic              gain;

  always_comb begin
    in_acq    = (err > lock_lo) && (err < lock_hi);
    in_hold   = (err > unlock_lo) && (err < unlock_hi);
    qual_eff  = (qual_count == '0) ? QUAL_W'(1) : qual_count;
    keep_lock = (st_q == ST_HOLD) && valid && in_hold;
    lose      = engage && (st_q == ST_HOLD) && valid && !in_hold;
    gain      = (st_q == ST_ACQ) && valid && in_acq &&
                ((run_q + 1'b1) >= qual_eff);
  end

  always_ff @(posedge clk) begin
    if (rst || !engage) begin
      st_q     <= ST_ACQ;
      run_q    <= '0;
      div_half <= 1'b1;
    end else if (valid) begin
      if (st_q == ST_HOLD) begin
        if (!in_hold) st_q <= ST_ACQ;
        run_q <= '0;
      end else if (!in_acq) begin
        run_q <= '0;
      end else if (gain) begin
        st_q     <= ST_HOLD;
        run_q    <= '0;
        div_half <= 1'b0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  // The flag survives mode exit; only reset or an acknowledge clears it.
  always_ff @(posedge clk) begin
    if (rst)          lol_flag <= 1'b0;
    else if (lose)    lol_flag <= 1'b1;
    else if (lol_ack) lol_flag <= 1'b0;
  end

  assign locked = (st_q == ST_HOLD);
endmodule

// File: rtl/fll_err_avg.sv
// Loop-filter feed: raw error per sample while acquiring, mean of four
// retained samples while lock holds.
module fll_err_avg #(
  parameter int ERR_W = 11,
  localparam int ACC_W = ERR_W + 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    engage,
  input  logic signed [ERR_W-1:0] err,
  input  logic                    valid,
  input  logic                    keep_lock,
  output logic                    upd_q,
  output logic signed [ERR_W-1:0] out_q
);
  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] sum_n;
  logic signed [ACC_W-1:0] mean;
  logic [1:0]              phase_q;

  always_comb begin
    sum_n = acc_q + ACC_W'(err);
    mean  = sum_n >>> 2;
  end

  always_ff @(posedge clk) begin
    if (rst || !engage) begin
      acc_q   <= '0;
      phase_q <= '0;
      upd_q   <= 1'b0;
      out_q   <= '0;
    end else begin
      upd_q <= 1'b0;
      if (valid) begin
        if (keep_lock) begin
          if (phase_q == 2'd3) begin
            upd_q   <= 1'b1;
            out_q   <= mean[ERR_W-1:0];
            acc_q   <= '0;
            phase_q <= '0;
          end else begin
            acc_q   <= sum_n;
            phase_q <= phase_q + 1'b1;
          end
        end else begin
          upd_q   <= 1'b1;
          out_q   <= err;
          acc_q   <= '0;
          phase_q <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/fll_lock_det.sv
module fll_lock_det #(
  parameter int CNT_W  = 10,
  parameter int QUAL_W = 4,
  localparam int ERR_W = CNT_W + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    engage,
  input  logic                    dco_pulse,
  input  logic                    cmp_end,
  input  logic [CNT_W-1:0]        mult_val,
  input  logic signed [ERR_W-1:0] lock_lo,
  input  logic signed [ERR_W-1:0] lock_hi,
  input  logic signed [ERR_W-1:0] unlock_lo,
  input  logic signed [ERR_W-1:0] unlock_hi,
  input  logic [QUAL_W-1:0]       qual_count,
  input  logic                    lol_ack,
  output logic signed [ERR_W-1:0] count_err,
  output logic                    err_valid,
  output logic                    filt_upd,
  output logic signed [ERR_W-1:0] filt_err,
  output logic                    locked,
  output logic                    lol_flag,
  output logic                    div_half
);
  logic keep_lock;

  fll_pulse_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .engage(engage), .dco_pulse(dco_pulse),
    .cmp_end(cmp_end), .mult_val(mult_val),
    .err_q(count_err), .valid_q(err_valid)
  );

  fll_lock_track #(.ERR_W(ERR_W), .QUAL_W(QUAL_W)) u_trk (
    .clk(clk), .rst(rst), .engage(engage), .err(count_err), .valid(err_valid),
    .lock_lo(lock_lo), .lock_hi(lock_hi),
    .unlock_lo(unlock_lo), .unlock_hi(unlock_hi),
    .qual_count(qual_count), .lol_ack(lol_ack),
    .locked(locked), .lol_flag(lol_flag), .div_half(div_half),
    .keep_lock(keep_lock)
  );

  fll_err_avg #(.ERR_W(ERR_W)) u_avg (
    .clk(clk), .rst(rst), .engage(engage), .err(count_err), .valid(err_valid),
    .keep_lock(keep_lock), .upd_q(filt_upd), .out_q(filt_err)
  );
endmodule

// File: rtl/fll_lock_det_chk.sv
module fll_lock_det_chk #(
  parameter int ERR_W = 11
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    engage,
  input logic signed [ERR_W-1:0] count_err,
  input logic                    err_valid,
  input logic signed [ERR_W-1:0] lock_lo,
  input logic signed [ERR_W-1:0] lock_hi,
  input logic signed [ERR_W-1:0] unlock_lo,
  input logic signed [ERR_W-1:0] unlock_hi,
  input logic                    lol_ack,
  input logic                    filt_upd,
  input logic                    locked,
  input logic                    lol_flag,
  input logic                    div_half
);
  // R3: a lock is only ever taken on a sample inside the acquisition window
  p_lock_from_window_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> ($past(err_valid) && ($past(count_err) > $past(lock_lo))
                       && ($past(count_err) < $past(lock_hi))));

  // R4: a sample outside the hold window ends the lock and raises the flag
  p_drop_outside_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (engage && locked && err_valid &&
     !((count_err > unlock_lo) && (count_err < unlock_hi)))
    |=> (!locked && lol_flag));

  // R5: the flag cannot clear without an acknowledge
  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (lol_flag && !lol_ack) |=> lol_flag);

  // R8: once divide-by-R is chosen it stays while engaged
  p_div_keeps_r8: assert property (@(posedge clk) disable iff (rst)
    (!div_half && engage) |=> !div_half);

  // R6: a filter strobe always follows a sample
  p_upd_after_sample_r6: assert property (@(posedge clk) disable iff (rst)
    filt_upd |-> $past(err_valid));

  // R9: mode exit forces the idle state
  p_mode_exit_r9: assert property (@(posedge clk) disable iff (rst)
    !engage |=> (!locked && div_half && !err_valid && !filt_upd));
endmodule

bind fll_lock_det fll_lock_det_chk #(.ERR_W(ERR_W)) u_chk (
  .clk(clk), .rst(rst), .engage(engage), .count_err(count_err),
  .err_valid(err_valid), .lock_lo(lock_lo), .lock_hi(lock_hi),
  .unlock_lo(unlock_lo), .unlock_hi(unlock_hi), .lol_ack(lol_ack),
  .filt_upd(filt_upd), .locked(locked), .lol_flag(lol_flag),
  .div_half(div_half)
);

// File: tb/fll_lock_det_tb.sv
module fll_lock_det_tb;
  localparam int CNT_W  = 10;
  localparam int QUAL_W = 4;
  localparam int ERR_W  = CNT_W + 1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                    rst = 1'b1, engage = 1'b0, dco_pulse = 1'b0;
  logic                    cmp_end = 1'b0, lol_ack = 1'b0;
  logic [CNT_W-1:0]        mult_val = 10;
  logic signed [ERR_W-1:0] lock_lo = -2, lock_hi = 2;
  logic signed [ERR_W-1:0] unlock_lo = -5, unlock_hi = 5;
  logic [QUAL_W-1:0]       qual_count = 3;
  logic signed [ERR_W-1:0] count_err, filt_err;
  logic                    err_valid, filt_upd, locked, lol_flag, div_half;

  fll_lock_det #(.CNT_W(CNT_W), .QUAL_W(QUAL_W)) u_dut (.*);

  int errors = 0, checks = 0;
  bit done = 0;

  // model state
  bit m_locked = 0, m_lol = 0, m_half = 1;
  int m_run = 0, m_phase = 0, m_acc = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    m_locked = 0; m_half = 1; m_run = 0; m_phase = 0; m_acc = 0;
  endtask

  // One comparison cycle with n pulses before the end strobe, plus an
  // optional pulse on the end cycle itself.
  task automatic comp(int n, bit endp);
    int e, em, qe, val;
    bit upd;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); dco_pulse = 1'b1; cmp_end = 1'b0;
    end
    @(negedge clk); dco_pulse = endp; cmp_end = 1'b1;
    @(negedge clk); dco_pulse = 1'b0; cmp_end = 1'b0;
    em = (int'(mult_val) < 4) ? 4 : int'(mult_val);
    e  = n + int'(endp) - em;
    chk("R1 valid", int'(err_valid), 1);
    chk(int'(mult_val) < 4 ? "R2 error" : "R1 error", int'(count_err), e);
    qe = (qual_count == 0) ? 1 : int'(qual_count);
    upd = 1; val = e;
    if (m_locked) begin
      if (e > int'(unlock_lo) && e < int'(unlock_hi)) begin
        if (m_phase == 3) begin
          val = (m_acc + e) >>> 2; m_acc = 0; m_phase = 0;
        end else begin
          upd = 0; m_acc += e; m_phase++;
        end
      end else begin
        m_locked = 0; m_lol = 1; m_acc = 0; m_phase = 0; m_run = 0;
      end
    end else if (e > int'(lock_lo) && e < int'(lock_hi)) begin
      if (m_run + 1 >= qe) begin
        m_locked = 1; m_half = 0; m_run = 0;
      end else m_run++;
    end else m_run = 0;
    @(negedge clk);
    chk("R3 locked", int'(locked), int'(m_locked));
    chk("R4 lol_flag", int'(lol_flag), int'(m_lol));
    chk("R8 div_half", int'(div_half), int'(m_half));
    chk(m_locked ? "R7 filt_upd" : "R6 filt_upd", int'(filt_upd), int'(upd));
    if (upd) chk(m_locked ? "R7 filt_err" : "R6 filt_err", int'(filt_err), val);
  endtask

  task automatic comp_err(int e);
    comp(e + int'(mult_val), 1'b0);
  endtask

  task automatic ack();
    @(negedge clk); lol_ack = 1'b1;
    @(negedge clk); lol_ack = 1'b0;
    m_lol = 0;
    chk("R5 ack clears", int'(lol_flag), 0);
  endtask

  task automatic mode_exit();
    @(negedge clk); engage = 1'b0; cmp_end = 1'b1;
    @(negedge clk); cmp_end = 1'b0;
    chk("R9 locked", int'(locked), 0);
    chk("R9 div_half", int'(div_half), 1);
    chk("R9 err_valid", int'(err_valid), 0);
    chk("R9 filt_upd", int'(filt_upd), 0);
    chk("R5 kept over exit", int'(lol_flag), int'(m_lol));
    model_clear();
    @(negedge clk); engage = 1'b1;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 count_err", int'(count_err), 0);
    chk("R10 err_valid", int'(err_valid), 0);
    chk("R10 filt_upd", int'(filt_upd), 0);
    chk("R10 filt_err", int'(filt_err), 0);
    chk("R10 locked", int'(locked), 0);
    chk("R10 lol_flag", int'(lol_flag), 0);
    chk("R10 div_half", int'(div_half), 1);
    rst = 1'b0; engage = 1'b1;
    @(negedge clk);

    // Sweep of pulse counts: locks at error +1, loses at +5 (R3, R4).
    for (int n = 0; n <= 20; n++) comp(n, 1'b0);
    repeat (4) @(negedge clk);
    chk("R5 sticky", int'(lol_flag), 1);
    ack();

    // Run restart: in, in, out, in, in, in (R3)
    comp_err(0); comp_err(1); comp_err(3); comp_err(-1); comp_err(0);
    chk("R3 not yet", int'(locked), 0);
    comp_err(1);
    // Averaging with mixed signs (R7)
    comp_err(-4); comp_err(3); comp_err(-3); comp_err(2);
    comp_err(4);  comp_err(4); comp_err(4);  comp_err(3);
    comp_err(-4); comp_err(-4); comp_err(-4); comp_err(-3);
    comp_err(2);  comp_err(-5);   // loss mid-phase, raw update (R6)
    chk("R8 after loss", int'(div_half), 0);
    comp_err(0); comp_err(0); comp_err(0); // relock, flag still set (R5)
    chk("R5 relock keeps flag", int'(lol_flag), 1);
    mode_exit();
    ack();

    // Multiplier floor (R2)
    mult_val = 2; comp(4, 1'b0); comp(3, 1'b1);
    mult_val = 0; comp(5, 1'b1);
    mult_val = 3; comp(2, 1'b0);
    mode_exit();

    // qual_count 0 acts as one (R3)
    mult_val = 8; qual_count = 0;
    comp_err(5); comp_err(1);
    chk("R3 qual zero", int'(locked), 1);
    mode_exit();

    // Near-exhaustive sweep over multipliers and end-cycle pulses
    qual_count = 2;
    for (int m = 4; m <= 12; m++) begin
      mult_val = CNT_W'(m);
      for (int n = 0; n <= m + 6; n++) comp(n, n[0]);
      mode_exit();
    end
    qual_count = 4;
    mult_val = 6;
    for (int k = 0; k < 3; k++) for (int n = 3; n <= 9; n++) comp(n, 1'b0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule